// File: doc/BRIEF.md
# Multiplexed Byte-Lane Bus Interface

This block runs read and write cycles for one internal requester on a 16-bit bus whose data lines also carry the low address bits. The upper four address lines are separate pins. A request gives a 20-bit address, a byte or word size, a direction, write data and a flag that picks memory space or I/O space. The block accepts the request when it is idle. It then runs the bus cycle on its own and returns read data with a one-clock response pulse.

Each bus cycle has four phases. First the address goes out with a latch-enable pulse. Then the read or write strobe goes low. The block then waits while the target holds READY low. Last, the strobe is released. Bytes are placed little-endian on two byte lanes. The lanes in use are encoded on an active-low high-lane enable together with address bit 0. A word at an odd address is broken into two byte cycles.

Top module: `ad_bus_master`

## Requirements
- R1: After reset, and whenever no request is in progress: rdN and wrN are high, latchEn is low, adOe is low, reqReady is high and rspValid is low. A request is taken on a clock edge where reqValid and reqReady are both high. reqReady stays low until the response pulse has ended.
- R2: Timing of the address phase. In the first clock after a request is taken, latchEn is high, adOe is high and adOut carries address bits 15:0. The next clock starts the strobe phase, with latchEn low.
- R3: Each bus cycle lasts 4 clocks plus one clock for every wait-phase clock in which readyIn is sampled low. rspValid is high for exactly one clock, which is the last clock of the final bus cycle.
- R4: Lane encoding, with A0 being adOut[0] in the address phase:
  - a word at an even address gives hiEnN=0, A0=0;
  - a byte at an even address gives hiEnN=1, A0=0;
  - a byte at an odd address gives hiEnN=0, A0=1;
  - the pair hiEnN=1, A0=1 is never driven.
- R5: Write data steering during the strobe. adOut carries:
  - for a word at an even address, the whole word, with bits 7:0 on the low lane;
  - for a byte at an even address, {8'h00, byte};
  - for a byte at an odd address, {byte, 8'h00};
  - in every case the write byte is reqWdata[7:0].
- R6: For a read, adOe is low whenever rdN is low. A byte read returns the byte from the active lane in rspRdata[7:0], with rspRdata[15:8] set to zero. A word read returns adIn unchanged.
- R7: A word at an odd address takes two bus cycles:
  - first cycle: the odd address, hiEnN=0, A0=1, data bits 7:0 on the high lane;
  - second cycle: the address plus one, hiEnN=1, A0=0, data bits 15:8 on the low lane;
  - with zero waits this takes 8 clocks, with one response at the end;
  - a read assembles the result little-endian.
- R8: memSel is 1 for a memory request and 0 for an I/O request, for the whole cycle. hiAddr carries address bits 19:16 only in the address phase of a memory cycle, and is zero at all other times.
- R9: Only one strobe is low at a time. The strobe is low in the strobe and wait phases only, which makes 2 clocks plus the wait clocks in each bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block is idle and will take a request |
| reqAddr | input | 20 | Byte address of the access |
| reqWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqMem | input | 1 | 1 = memory space, 0 = I/O space |
| reqWdata | input | 16 | Write data; a byte write uses bits 7:0 |
| rspValid | output | 1 | One-clock pulse marking the end of the access |
| rspRdata | output | 16 | Read result, right-aligned for a byte read |
| adOut | output | 16 | Shared address/data lines, outgoing value |
| adIn | input | 16 | Shared address/data lines, incoming value |
| adOe | output | 1 | Output enable for the shared lines |
| hiAddr | output | 4 | Upper address lines |
| latchEn | output | 1 | Address latch enable |
| memSel | output | 1 | 1 = memory cycle, 0 = I/O cycle |
| rdN | output | 1 | Read strobe, active low |
| wrN | output | 1 | Write strobe, active low |
| hiEnN | output | 1 | High byte lane enable, active low |
| readyIn | input | 1 | Target ready; low inserts wait states |

## Verification
The assertions check the following on every cycle:
- the two strobes are never low together;
- the undefined lane pair is never driven;
- the shared lines are released whenever the read strobe is low;
- the upper address lines stay zero in I/O cycles;
- the phase order from address phase to strobe phase;
- a low READY in the wait phase keeps the wait phase;
- the response lasts a single clock.

Only the bench scenarios can show the rest:
- the actual byte placement on the lanes for each size and alignment;
- the right-alignment and zero-fill of byte reads;
- the two-cycle split of an odd word and its little-endian assembly;
- the clock count under different wait-state patterns.

The bench checks these against a byte-wide memory model that sits on the bus.

// File: rtl/adbus_pkg.sv
package adbus_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_STRB,
    PH_WAIT,
    PH_REL
  } phase_t;

  typedef struct packed {
    logic load;      // capture a new request
    logic ale;       // address phase
    logic strobe;    // strobe and wait phases
    logic drive;     // write data may be on the lines
    logic capture;   // read data sampled this edge
    logic nextPart;  // advance to the second half of a split word
    logic partTwo;   // current bus cycle is the second half
    logic active;    // an access is in progress
  } busCtl_t;

endpackage

// File: rtl/adbus_seq.sv
module adbus_seq
  import adbus_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    readyIn,
  input  logic    needSplit,
  output busCtl_t ctl,
  output logic    reqReady,
  output logic    rspValid
);

  phase_t state, stateNext;
  logic   partTwo;

  always_comb begin
    stateNext = state;
    case (state)
      PH_IDLE: if (reqValid) stateNext = PH_ADDR;
      PH_ADDR: stateNext = PH_STRB;
      PH_STRB: stateNext = PH_WAIT;
      PH_WAIT: if (readyIn) stateNext = PH_REL;
      PH_REL:  stateNext = (needSplit && !partTwo) ? PH_ADDR : PH_IDLE;
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      partTwo <= 1'b0;
    end else begin
      state <= stateNext;
      if (ctl.load)          partTwo <= 1'b0;
      else if (ctl.nextPart) partTwo <= 1'b1;
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.load     = (state == PH_IDLE) && reqValid;
    ctl.ale      = (state == PH_ADDR);
    ctl.strobe   = (state == PH_STRB) || (state == PH_WAIT);
    ctl.drive    = (state == PH_STRB) || (state == PH_WAIT) || (state == PH_REL);
    ctl.capture  = (state == PH_WAIT) && readyIn;
    ctl.nextPart = (state == PH_REL) && needSplit && !partTwo;
    ctl.partTwo  = partTwo;
    ctl.active   = (state != PH_IDLE);
  end

  assign reqReady = (state == PH_IDLE);
  assign rspValid = (state == PH_REL) && (!needSplit || partTwo);

  AST_ALE_LEADS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    state == PH_ADDR |=> state == PH_STRB); // R2

  AST_WAIT_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_WAIT && !readyIn) |=> state == PH_WAIT); // R3

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid); // R3

  AST_SPLIT_REISSUE: assert property (@(posedge clk) disable iff (!rstN)
    ctl.nextPart |=> (state == PH_ADDR && partTwo)); // R7

endmodule

// File: rtl/adbus_lanes.sv
module adbus_lanes
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  busCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWord,
  input  logic              reqWrite,
  input  logic              reqMem,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] adIn,
  output logic              needSplit,
  output logic [DATA_W-1:0] adOut,
  output logic              adOe,
  output logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic              latchEn,
  output logic              memSel,
  output logic              rdN,
  output logic              wrN,
  output logic              hiEnN,
  output logic [DATA_W-1:0] rspRdata
);

  localparam int LANE_W = DATA_W / 2;
  localparam int HI_W   = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] wdReg;
  logic [DATA_W-1:0] rdBuf;
  logic              isWord, isWrite, isMem, oddStart;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr  <= '0;
      wdReg    <= '0;
      isWord   <= 1'b0;
      isWrite  <= 1'b0;
      isMem    <= 1'b0;
      oddStart <= 1'b0;
    end else if (ctl.load) begin
      curAddr  <= reqAddr;
      wdReg    <= reqWdata;
      isWord   <= reqWord;
      isWrite  <= reqWrite;
      isMem    <= reqMem;
      oddStart <= reqAddr[0];
    end else if (ctl.nextPart) begin
      curAddr  <= curAddr + ADDR_W'(1);
    end
  end

  assign needSplit = isWord && oddStart;

  // lane use for the current bus cycle
  logic hiUse, loUse;
  always_comb begin
    if (isWord && !oddStart) begin
      hiUse = 1'b1;
      loUse = 1'b1;
    end else if (needSplit) begin
      hiUse = !ctl.partTwo;
      loUse = ctl.partTwo;
    end else begin
      hiUse = curAddr[0];
      loUse = !curAddr[0];
    end
  end

  // little-endian write steering
  logic [LANE_W-1:0] wrByte;
  logic [DATA_W-1:0] wrLanes;
  always_comb begin
    wrByte = (needSplit && ctl.partTwo) ? wdReg[DATA_W-1:LANE_W] : wdReg[LANE_W-1:0];
    if (hiUse && loUse)  wrLanes = wdReg;
    else if (hiUse)      wrLanes = {wrByte, {LANE_W{1'b0}}};
    else                 wrLanes = {{LANE_W{1'b0}}, wrByte};
  end

  always_comb begin
    if (ctl.ale)                      adOut = curAddr[DATA_W-1:0];
    else if (ctl.drive && isWrite)    adOut = wrLanes;
    else                              adOut = '0;
  end

  assign adOe    = ctl.ale || (ctl.drive && isWrite);
  assign hiAddr  = (ctl.ale && isMem) ? curAddr[ADDR_W-1:DATA_W] : '0;
  assign latchEn = ctl.ale;
  assign memSel  = isMem;
  assign rdN     = !(ctl.strobe && !isWrite);
  assign wrN     = !(ctl.strobe && isWrite);
  assign hiEnN   = ctl.active ? !hiUse : 1'b1;

  // read capture, right-aligned
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdBuf <= '0;
    end else if (ctl.capture && !isWrite) begin
      if (hiUse && loUse)
        rdBuf <= adIn;
      else if (needSplit && ctl.partTwo)
        rdBuf[DATA_W-1:LANE_W] <= adIn[LANE_W-1:0];
      else if (needSplit)
        rdBuf <= {{LANE_W{1'b0}}, adIn[DATA_W-1:LANE_W]};
      else if (hiUse)
        rdBuf <= {{LANE_W{1'b0}}, adIn[DATA_W-1:LANE_W]};
      else
        rdBuf <= {{LANE_W{1'b0}}, adIn[LANE_W-1:0]};
    end
  end

  assign rspRdata = rdBuf;

  AST_NO_UNDEF_LANE: assert property (@(posedge clk) disable iff (!rstN)
    latchEn |-> !(hiEnN && adOut[0])); // R4

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN)); // R9

  AST_READ_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> !adOe); // R6

  AST_IO_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !memSel |-> hiAddr == '0); // R8

  AST_HI_STABLE_IN_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    (!latchEn && !rdN) |=> (rdN || $stable(hiEnN))); // R4

  initial begin
    assert (HI_W > 0); // R8
  end

endmodule

// File: rtl/ad_bus_master.sv
module ad_bus_master
  import adbus_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     reqValid,
  output logic                     reqReady,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic                     reqWord,
  input  logic                     reqWrite,
  input  logic                     reqMem,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     rspValid,
  output logic [DATA_W-1:0]        rspRdata,
  output logic [DATA_W-1:0]        adOut,
  input  logic [DATA_W-1:0]        adIn,
  output logic                     adOe,
  output logic [ADDR_W-DATA_W-1:0] hiAddr,
  output logic                     latchEn,
  output logic                     memSel,
  output logic                     rdN,
  output logic                     wrN,
  output logic                     hiEnN,
  input  logic                     readyIn
);

  busCtl_t ctl;
  logic    needSplit;

  adbus_seq u_seq (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .readyIn   (readyIn),
    .needSplit (needSplit),
    .ctl       (ctl),
    .reqReady  (reqReady),
    .rspValid  (rspValid)
  );

  adbus_lanes #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lanes (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqAddr   (reqAddr),
    .reqWord   (reqWord),
    .reqWrite  (reqWrite),
    .reqMem    (reqMem),
    .reqWdata  (reqWdata),
    .adIn      (adIn),
    .needSplit (needSplit),
    .adOut     (adOut),
    .adOe      (adOe),
    .hiAddr    (hiAddr),
    .latchEn   (latchEn),
    .memSel    (memSel),
    .rdN       (rdN),
    .wrN       (wrN),
    .hiEnN     (hiEnN),
    .rspRdata  (rspRdata)
  );

endmodule

// File: tb/ad_bus_master_bench.sv
module ad_bus_master_bench;

  typedef struct packed {
    logic [19:0] addr;
    logic        word;
    logic        wr;
    logic        mem;
    logic [15:0] wd;
    logic [3:0]  waits;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{20'hA5010, 1'b1, 1'b1, 1'b1, 16'h1234, 4'd0, 16'h0000},
    '{20'hA5010, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd0, 16'h1234},
    '{20'hA5010, 1'b0, 1'b0, 1'b1, 16'h0000, 4'd0, 16'h0034},
    '{20'hA5011, 1'b0, 1'b0, 1'b1, 16'h0000, 4'd2, 16'h0012},
    '{20'hA5013, 1'b0, 1'b1, 1'b1, 16'h00CD, 4'd0, 16'h0000},
    '{20'hA5012, 1'b0, 1'b1, 1'b1, 16'h00AB, 4'd1, 16'h0000},
    '{20'hA5012, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd0, 16'hCDAB},
    '{20'hA5015, 1'b1, 1'b1, 1'b1, 16'hBEEF, 4'd0, 16'h0000},
    '{20'hA5015, 1'b1, 1'b0, 1'b1, 16'h0000, 4'd1, 16'hBEEF},
    '{20'hA5016, 1'b0, 1'b0, 1'b1, 16'h0000, 4'd0, 16'h00BE},
    '{20'h0F00E, 1'b1, 1'b1, 1'b0, 16'h5A5A, 4'd0, 16'h0000},
    '{20'h0F00E, 1'b1, 1'b0, 1'b0, 16'h0000, 4'd3, 16'h5A5A}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [19:0] reqAddr = '0;
  logic        reqWord = 1'b0;
  logic        reqWrite = 1'b0;
  logic        reqMem = 1'b0;
  logic [15:0] reqWdata = '0;
  logic [15:0] adIn;
  logic        readyIn = 1'b1;
  logic        reqReady, rspValid, adOe, latchEn, memSel, rdN, wrN, hiEnN;
  logic [15:0] rspRdata, adOut;
  logic [3:0]  hiAddr;

  ad_bus_master u_ad_bus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqWord(reqWord), .reqWrite(reqWrite), .reqMem(reqMem),
    .reqWdata(reqWdata), .rspValid(rspValid), .rspRdata(rspRdata),
    .adOut(adOut), .adIn(adIn), .adOe(adOe), .hiAddr(hiAddr),
    .latchEn(latchEn), .memSel(memSel), .rdN(rdN), .wrN(wrN),
    .hiEnN(hiEnN), .readyIn(readyIn)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bus-side memory model and monitors
  logic [7:0]  mem [0:31];
  logic [4:0]  slvAddr = '0;
  logic        slvHiEnN = 1'b1;
  logic        slvA0 = 1'b0;
  int          strbCnt = 0;
  int          waitsCur = 0;
  int          busCyc = 0;
  int          strbTotal = 0;
  logic [15:0] aleAd [2];
  logic [3:0]  aleHi [2];
  logic        aleMem [2];
  logic        aleHiEnN [2];
  logic [15:0] wrSeen [2];
  bit          rdOeBad = 0;
  bit          hiBad = 0;
  bit          bothBad = 0;

  assign adIn = {mem[{slvAddr[4:1], 1'b1}], mem[{slvAddr[4:1], 1'b0}]};

  always @(negedge clk) begin
    if (rstN) begin
      if (latchEn) begin
        slvAddr  <= adOut[4:0];
        slvHiEnN <= hiEnN;
        slvA0    <= adOut[0];
        if (busCyc < 2) begin
          aleAd[busCyc]    <= adOut;
          aleHi[busCyc]    <= hiAddr;
          aleMem[busCyc]   <= memSel;
          aleHiEnN[busCyc] <= hiEnN;
        end
        busCyc <= busCyc + 1;
      end else if (hiAddr != 4'h0) begin
        hiBad <= 1'b1;
      end
      if (!rdN && adOe) rdOeBad <= 1'b1;
      if (!rdN && !wrN) bothBad <= 1'b1;
      if (!rdN || !wrN) begin
        strbCnt   <= strbCnt + 1;
        strbTotal <= strbTotal + 1;
        readyIn   <= (strbCnt + 1 >= waitsCur + 2);
      end else begin
        strbCnt <= 0;
        readyIn <= 1'b1;
      end
      if (!wrN) begin
        if (busCyc >= 1 && busCyc <= 2) wrSeen[busCyc-1] <= adOut;
        if (!slvHiEnN) mem[{slvAddr[4:1], 1'b1}] <= adOut[15:8];
        if (!slvA0)    mem[{slvAddr[4:1], 1'b0}] <= adOut[7:0];
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 20000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic runVec(input vec_t v);
    bit          split;
    int          nBus, clocks;
    logic [19:0] pa;
    logic        eHiN, eA0;
    logic [15:0] eWr;
    split = v.word && v.addr[0];
    nBus  = split ? 2 : 1;
    @(negedge clk);
    busCyc = 0; strbTotal = 0; rdOeBad = 0; hiBad = 0; bothBad = 0;
    waitsCur = v.waits;
    check(reqReady == 1'b1, "R1 ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = v.addr; reqWord = v.word; reqWrite = v.wr;
    reqMem = v.mem; reqWdata = v.wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(latchEn == 1'b1 && adOe == 1'b1, "R2 ale with drive", {latchEn, adOe}, 2'b11);
    check(reqReady == 1'b0, "R1 busy during access", reqReady, 0);
    clocks = 1;
    while (!rspValid && clocks < 200) begin
      @(negedge clk);
      clocks++;
      if (clocks == 2) check(latchEn == 1'b0 && (!rdN || !wrN), "R2 strobe follows ale", {latchEn, rdN, wrN}, 0);
    end
    #1;
    check(clocks == nBus * (4 + v.waits), split ? "R7 split clock count" : "R3 clock count", clocks, nBus * (4 + v.waits));
    check(busCyc == nBus, "R7 bus cycle count", busCyc, nBus);
    check(strbTotal == nBus * (2 + v.waits), "R9 strobe width", strbTotal, nBus * (2 + v.waits));
    check(!hiBad, "R8 upper lines zero outside address phase", hiBad, 0);
    check(!bothBad, "R9 single strobe", bothBad, 0);
    for (int p = 0; p < nBus && p < 2; p++) begin
      pa = v.addr + 20'(p);
      if (v.word && !v.addr[0]) begin eHiN = 1'b0; eA0 = 1'b0; eWr = v.wd; end
      else if (split && p == 0) begin eHiN = 1'b0; eA0 = 1'b1; eWr = {v.wd[7:0], 8'h00}; end
      else if (split)           begin eHiN = 1'b1; eA0 = 1'b0; eWr = {8'h00, v.wd[15:8]}; end
      else if (v.addr[0])       begin eHiN = 1'b0; eA0 = 1'b1; eWr = {v.wd[7:0], 8'h00}; end
      else                      begin eHiN = 1'b1; eA0 = 1'b0; eWr = {8'h00, v.wd[7:0]}; end
      check(aleAd[p] == pa[15:0], "R2 address low lines", aleAd[p], pa[15:0]);
      check(aleHi[p] == (v.mem ? pa[19:16] : 4'h0), "R8 upper address", aleHi[p], v.mem ? pa[19:16] : 4'h0);
      check(aleMem[p] == v.mem, "R8 memory select", aleMem[p], v.mem);
      check({aleHiEnN[p], aleAd[p][0]} == {eHiN, eA0}, split ? "R7 split lanes" : "R4 lane pair", {aleHiEnN[p], aleAd[p][0]}, {eHiN, eA0});
      if (v.wr) check(wrSeen[p] == eWr, split ? "R7 split write lanes" : "R5 write steering", wrSeen[p], eWr);
    end
    if (!v.wr) begin
      check(rspRdata == v.exp, split ? "R7 split read assembly" : "R6 read alignment", rspRdata, v.exp);
      check(!rdOeBad, "R6 lines released on read", rdOeBad, 0);
    end
    @(negedge clk);
    check(rspValid == 1'b0 && reqReady == 1'b1, "R3 single response then idle", {rspValid, reqReady}, 2'b01);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mem[i] = 8'h00;
    aleAd = '{16'h0, 16'h0}; aleHi = '{4'h0, 4'h0};
    aleMem = '{1'b0, 1'b0}; aleHiEnN = '{1'b1, 1'b1}; wrSeen = '{16'h0, 16'h0};
    repeat (3) @(negedge clk);
    check(rdN && wrN && !latchEn && !adOe && reqReady && !rspValid, "R1 reset state",
          {rdN, wrN, latchEn, adOe, reqReady, rspValid}, 6'b110010);
    rstN = 1'b1;
    @(negedge clk);
    check(rdN && wrN && !latchEn && reqReady, "R1 idle after reset", {rdN, wrN, latchEn, reqReady}, 4'b1101);

    for (int k = 0; k < NV; k++) runVec(VECS[k]);

    // stored byte order in the bus model: little-endian placement
    check({mem[5'h11], mem[5'h10]} == 16'h1234, "R5 little-endian word store", {mem[5'h11], mem[5'h10]}, 16'h1234);
    check({mem[5'h16], mem[5'h15]} == 16'hBEEF, "R7 split store order", {mem[5'h16], mem[5'h15]}, 16'hBEEF);

    // reset while stretched in the wait phase
    @(negedge clk);
    waitsCur = 12;
    reqValid = 1'b1; reqAddr = 20'hA5010; reqWord = 1'b1; reqWrite = 1'b0; reqMem = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    repeat (4) @(negedge clk);
    check(rdN == 1'b0, "R3 wait stretches strobe", rdN, 0);
    rstN = 1'b0;
    #1;
    check(rdN && wrN && !latchEn && !adOe && reqReady && !rspValid, "R1 reset aborts access",
          {rdN, wrN, latchEn, adOe, reqReady, rspValid}, 6'b110010);
    @(negedge clk);
    rstN = 1'b1;
    waitsCur = 0;
    repeat (2) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule